// File: doc/BRIEF.md
# Counted Master Transfer Sequencer

This block steps a byte-level serial bus engine through master-mode transfers. The host programs a control word, a slave address and a 16-bit transfer count. When enable, master and start are written together, the sequencer asks the engine for a start with the address, and then for byte sends or byte receives. It finishes with a stop when one has been requested. A four-entry byte buffer sits between the host data port and the engine. Bytes leave the buffer in the order they were pushed.

In count mode, a working copy of the count is loaded at start and decremented per byte. When it reaches zero, the sequencer flags access-ready and drops the master bit. In repeat mode the count is left alone: transmit sends whatever is buffered, receive takes one byte each time the buffer has been emptied, and a stop is sent only when the host asks for it. The start and stop bits clear themselves once they have been acted on.

Engine commands use a request/done handshake with one command outstanding at a time. The op codes are start 0, send 1, receive 2 and stop 3. A start carries the byte {address[6:0], read}, where read is the inverse of the direction bit.

Top module: `mxfer_seq`

## Requirements
- R1: A control write stores its data ANDed with 0xcf87. Bit positions: 15 enable, 10 master, 9 transmit, 8 wide-address request, 2 repeat, 1 stop, 0 start.
- R2: Writing enable, master and start together while idle issues engine op 0 with data {sa[6:0], ~bit9}. The request is held with a stable op and data until done. Start (bit 0) reads back 0 after the start completes.
- R3: A start answered without an acknowledge sets nack_o and returns to idle with no further command.
- R4: The working count on cnt_o is loaded from the count register at start, and decrements once per byte in count mode.
- R5: Count-mode transmit sends buffered bytes (op 1) in push order while the count is non-zero. xrdy_o rises when the buffer runs dry with count left, and a host push clears it.
- R6: When the working count reaches zero, ardy_o is set, master (bit 10) is cleared and xrdy_o is cleared.
- R7: If stop (bit 1) is set when the count reaches zero, op 3 is issued. Afterwards stop reads 0, the working count is reloaded and the block is idle.
- R8: Count-mode receive (op 2) fills the buffer until it holds 4 bytes or the count is exhausted, then sets rrdy_o. Popping the buffer empty clears rrdy_o.
- R9: In repeat mode cnt_o does not change during the transfer, transmit drains the buffer, master stays set, and a stop is issued only after the host sets bit 1.
- R10: In repeat-mode receive, one byte is fetched each time the buffer is empty, which sets rrdy_o. A stop request is served at the next step.
- R11: A send answered without an acknowledge sets nack_o, clears stop, issues no stop and returns to idle.
- R12: Enable with start but with master clear, or with bit 8 set, issues no command.
- R13: stat_clr_i[0] clears nack_o and stat_clr_i[1] clears ardy_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control write strobe |
| ctrl_wdata_i | input | 16 | Control write data |
| ctrl_o | output | 16 | Control word readback |
| sa_i | input | 10 | Slave address |
| cnt_we_i | input | 1 | Count register write strobe |
| cnt_wdata_i | input | 16 | Count register write data |
| cnt_o | output | 16 | Working count |
| wr_push_i | input | 1 | Push a byte into the buffer |
| wr_byte_i | input | 8 | Byte to push |
| rd_pop_i | input | 1 | Pop the buffer head |
| rd_byte_o | output | 8 | Buffer head |
| stat_clr_i | input | 2 | Clear nack (bit 0) and access-ready (bit 1) |
| nack_o | output | 1 | Missing-acknowledge flag |
| ardy_o | output | 1 | Access-ready flag |
| rrdy_o | output | 1 | Receive-ready flag |
| xrdy_o | output | 1 | Transmit-ready flag |
| busy_o | output | 1 | Sequencer not idle |
| eng_req_o | output | 1 | Engine command request |
| eng_op_o | output | 2 | Engine op code |
| eng_data_o | output | 8 | Address byte or byte to send |
| eng_done_i | input | 1 | Engine command complete |
| eng_ack_i | input | 1 | Acknowledge seen for start or send |
| eng_rdata_i | input | 8 | Received byte |

## Verification
The properties assume the engine pulses done for exactly one cycle and only while a request is up. They also assume the host never pushes into a full buffer, never pops an empty one, and never touches the buffer in the same cycle as the engine's own push or pop. The bench's engine model keeps to this by answering each request two cycles after it appears. The host tasks push only before or between transmit commands, and pop only received data or a byte left behind after a failed send. Control rewrites during a transfer keep enable, master and direction unchanged.

// File: rtl/mxfer_seq_pkg.sv
package mxfer_seq_pkg;
  typedef enum logic [1:0] {OP_START = 2'd0, OP_SEND = 2'd1, OP_RECV = 2'd2, OP_STOP = 2'd3} eng_op_e;
  typedef enum logic [1:0] {SQ_IDLE, SQ_RUN, SQ_WAIT} seq_state_e;

  localparam int CB_EN  = 15;
  localparam int CB_MST = 10;
  localparam int CB_TRX = 9;
  localparam int CB_XA  = 8;
  localparam int CB_RM  = 2;
  localparam int CB_STP = 1;
  localparam int CB_STT = 0;
  localparam logic [15:0] CTRL_MASK = 16'hcf87;

  localparam int FL_NACK = 0;
  localparam int FL_ARDY = 1;
  localparam int FL_RRDY = 2;
  localparam int FL_XRDY = 3;
  localparam int NFLAGS  = 4;
endpackage

// File: rtl/mxfer_seq_fifo.sv
module mxfer_seq_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  data_i,
  input  logic          pop_i,
  output logic [W-1:0]  head_o,
  output logic [LW-1:0] level_o,
  output logic          empty_o,
  output logic          full_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [LW-1:0] lvl_q;
  logic          do_push, do_pop;

  assign empty_o = (lvl_q == '0);
  assign full_o  = (lvl_q == LW'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign head_o  = mem_q[rp_q];
  assign level_o = lvl_q;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (do_push) begin
        mem_q[wp_q] <= data_i;
        wp_q        <= nxt(wp_q);
      end
      if (do_pop) rp_q <= nxt(rp_q);
      if (do_push && !do_pop) lvl_q <= lvl_q + LW'(1);
      else if (do_pop && !do_push) lvl_q <= lvl_q - LW'(1);
    end
  end
endmodule

// File: rtl/mxfer_seq_flags.sv
module mxfer_seq_flags #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  // clear wins over set
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q_o[g] <= 1'b0;
      else if (clr_i[g]) q_o[g] <= 1'b0;
      else if (set_i[g]) q_o[g] <= 1'b1;
    end
  end
endmodule

// File: rtl/mxfer_seq_core.sv
module mxfer_seq_core
  import mxfer_seq_pkg::*;
#(
  parameter int CW = 16,
  parameter int SW = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [15:0]       ctrl_wdata_i,
  input  logic [SW-1:0]     sa_i,
  input  logic              cnt_we_i,
  input  logic [CW-1:0]     cnt_wdata_i,
  input  logic              eng_done_i,
  input  logic              eng_ack_i,
  input  logic [7:0]        eng_rdata_i,
  input  logic              fifo_empty_i,
  input  logic              fifo_full_i,
  input  logic [7:0]        fifo_head_i,
  output logic [15:0]       ctrl_o,
  output logic [CW-1:0]     cnt_o,
  output logic              busy_o,
  output logic              eng_req_o,
  output logic [1:0]        eng_op_o,
  output logic [7:0]        eng_data_o,
  output logic              fifo_push_o,
  output logic [7:0]        fifo_wdata_o,
  output logic              fifo_pop_o,
  output logic [NFLAGS-1:0] flag_set_o,
  output logic [NFLAGS-1:0] flag_clr_o
);
  seq_state_e    st_q, st_d;
  logic [15:0]   ctrl_q, ctrl_d;
  logic [CW-1:0] cnt_reg_q, cnt_cur_q, cnt_cur_d;
  logic          req_q, req_d;
  eng_op_e       op_q, op_d;
  logic [7:0]    dat_q, dat_d;

  logic en, rm, trx, stp, cnt_zero, start_ok;
  assign en       = ctrl_q[CB_EN];
  assign rm       = ctrl_q[CB_RM];
  assign trx      = ctrl_q[CB_TRX];
  assign stp      = ctrl_q[CB_STP];
  assign cnt_zero = (cnt_cur_q == '0);
  assign start_ok = ctrl_we_i && ctrl_wdata_i[CB_EN] && ctrl_wdata_i[CB_MST] &&
                    !ctrl_wdata_i[CB_XA] && ctrl_wdata_i[CB_STT];

  always_comb begin
    st_d         = st_q;
    ctrl_d       = ctrl_we_i ? (ctrl_wdata_i & CTRL_MASK) : ctrl_q;
    cnt_cur_d    = cnt_cur_q;
    req_d        = req_q;
    op_d         = op_q;
    dat_d        = dat_q;
    flag_set_o   = '0;
    flag_clr_o   = '0;
    fifo_push_o  = 1'b0;
    fifo_pop_o   = 1'b0;
    unique case (st_q)
      SQ_IDLE: begin
        if (start_ok) begin
          cnt_cur_d = cnt_reg_q;
          req_d     = 1'b1;
          op_d      = OP_START;
          dat_d     = {sa_i[6:0], ~ctrl_wdata_i[CB_TRX]};
          st_d      = SQ_WAIT;
        end
      end
      SQ_WAIT: begin
        if (eng_done_i) begin
          req_d = 1'b0;
          st_d  = SQ_RUN;
          unique case (op_q)
            OP_START: begin
              ctrl_d[CB_STT] = 1'b0;
              if (!eng_ack_i) begin
                flag_set_o[FL_NACK] = 1'b1;
                st_d                = SQ_IDLE;
              end
            end
            OP_SEND: begin
              fifo_pop_o = 1'b1;
              if (!rm) cnt_cur_d = cnt_cur_q - CW'(1);
              if (!eng_ack_i) begin
                flag_set_o[FL_NACK] = 1'b1;
                ctrl_d[CB_STP]      = 1'b0;
                st_d                = SQ_IDLE;
              end
            end
            OP_RECV: begin
              fifo_push_o = 1'b1;
              if (!rm) cnt_cur_d = cnt_cur_q - CW'(1);
            end
            default: begin
              ctrl_d[CB_STP] = 1'b0;
              cnt_cur_d      = cnt_reg_q;
              st_d           = SQ_IDLE;
            end
          endcase
        end
      end
      SQ_RUN: begin
        if (!en) begin
          st_d = SQ_IDLE;
        end else if (rm) begin
          if (stp && (!trx || fifo_empty_i)) begin
            req_d = 1'b1; op_d = OP_STOP; st_d = SQ_WAIT;
          end else if (trx) begin
            if (!fifo_empty_i) begin
              req_d = 1'b1; op_d = OP_SEND; dat_d = fifo_head_i; st_d = SQ_WAIT;
            end else flag_set_o[FL_XRDY] = 1'b1;
          end else if (fifo_empty_i) begin
            req_d = 1'b1; op_d = OP_RECV; st_d = SQ_WAIT;
          end else flag_set_o[FL_RRDY] = 1'b1;
        end else if (cnt_zero) begin
          flag_set_o[FL_ARDY] = 1'b1;
          flag_clr_o[FL_XRDY] = 1'b1;
          ctrl_d[CB_MST]      = 1'b0;
          if (!trx && !fifo_empty_i) flag_set_o[FL_RRDY] = 1'b1;
          if (stp) begin
            req_d = 1'b1; op_d = OP_STOP; st_d = SQ_WAIT;
          end else st_d = SQ_IDLE;
        end else if (trx) begin
          if (!fifo_empty_i) begin
            req_d = 1'b1; op_d = OP_SEND; dat_d = fifo_head_i; st_d = SQ_WAIT;
          end else flag_set_o[FL_XRDY] = 1'b1;
        end else if (!fifo_full_i) begin
          req_d = 1'b1; op_d = OP_RECV; st_d = SQ_WAIT;
        end else flag_set_o[FL_RRDY] = 1'b1;
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= SQ_IDLE;
      ctrl_q    <= '0;
      cnt_reg_q <= '0;
      cnt_cur_q <= '0;
      req_q     <= 1'b0;
      op_q      <= OP_START;
      dat_q     <= '0;
    end else begin
      st_q      <= st_d;
      ctrl_q    <= ctrl_d;
      cnt_cur_q <= cnt_cur_d;
      req_q     <= req_d;
      op_q      <= op_d;
      dat_q     <= dat_d;
      if (cnt_we_i) cnt_reg_q <= cnt_wdata_i;
    end
  end

  assign ctrl_o       = ctrl_q;
  assign cnt_o        = cnt_cur_q;
  assign busy_o       = (st_q != SQ_IDLE);
  assign eng_req_o    = req_q;
  assign eng_op_o     = op_q;
  assign eng_data_o   = dat_q;
  assign fifo_wdata_o = eng_rdata_i;
endmodule

// File: rtl/mxfer_seq.sv
module mxfer_seq
  import mxfer_seq_pkg::*;
#(
  parameter int CW    = 16,
  parameter int SW    = 10,
  parameter int DEPTH = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ctrl_we_i,
  input  logic [15:0]   ctrl_wdata_i,
  output logic [15:0]   ctrl_o,
  input  logic [SW-1:0] sa_i,
  input  logic          cnt_we_i,
  input  logic [CW-1:0] cnt_wdata_i,
  output logic [CW-1:0] cnt_o,
  input  logic          wr_push_i,
  input  logic [7:0]    wr_byte_i,
  input  logic          rd_pop_i,
  output logic [7:0]    rd_byte_o,
  input  logic [1:0]    stat_clr_i,
  output logic          nack_o,
  output logic          ardy_o,
  output logic          rrdy_o,
  output logic          xrdy_o,
  output logic          busy_o,
  output logic          eng_req_o,
  output logic [1:0]    eng_op_o,
  output logic [7:0]    eng_data_o,
  input  logic          eng_done_i,
  input  logic          eng_ack_i,
  input  logic [7:0]    eng_rdata_i
);
  localparam int LW = $clog2(DEPTH + 1);

  logic              f_empty, f_full, f_push, f_pop, c_push, c_pop;
  logic [7:0]        f_head, f_wdata, c_wdata;
  logic [LW-1:0]     f_level;
  logic [NFLAGS-1:0] c_set, c_clr, fl_clr, fl_q;
  logic              host_pop, host_push;

  mxfer_seq_core #(.CW(CW), .SW(SW)) u_core (
    .clk_i, .rst_ni, .ctrl_we_i, .ctrl_wdata_i, .sa_i, .cnt_we_i, .cnt_wdata_i,
    .eng_done_i, .eng_ack_i, .eng_rdata_i,
    .fifo_empty_i(f_empty), .fifo_full_i(f_full), .fifo_head_i(f_head),
    .ctrl_o, .cnt_o, .busy_o, .eng_req_o, .eng_op_o, .eng_data_o,
    .fifo_push_o(c_push), .fifo_wdata_o(c_wdata), .fifo_pop_o(c_pop),
    .flag_set_o(c_set), .flag_clr_o(c_clr)
  );

  assign host_push = wr_push_i && !c_push && !f_full;
  assign host_pop  = rd_pop_i && !c_pop && !f_empty;
  assign f_push    = c_push || host_push;
  assign f_wdata   = c_push ? c_wdata : wr_byte_i;
  assign f_pop     = c_pop || host_pop;

  mxfer_seq_fifo #(.W(8), .DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni, .push_i(f_push), .data_i(f_wdata), .pop_i(f_pop),
    .head_o(f_head), .level_o(f_level), .empty_o(f_empty), .full_o(f_full)
  );

  always_comb begin
    fl_clr          = c_clr;
    fl_clr[FL_NACK] = fl_clr[FL_NACK] | stat_clr_i[0];
    fl_clr[FL_ARDY] = fl_clr[FL_ARDY] | stat_clr_i[1];
    fl_clr[FL_XRDY] = fl_clr[FL_XRDY] | host_push;
    fl_clr[FL_RRDY] = fl_clr[FL_RRDY] | (host_pop && !c_push && f_level == LW'(1));
  end

  mxfer_seq_flags #(.N(NFLAGS)) u_flags (
    .clk_i, .rst_ni, .set_i(c_set), .clr_i(fl_clr), .q_o(fl_q)
  );

  assign nack_o    = fl_q[FL_NACK];
  assign ardy_o    = fl_q[FL_ARDY];
  assign rrdy_o    = fl_q[FL_RRDY];
  assign xrdy_o    = fl_q[FL_XRDY];
  assign rd_byte_o = f_head;
endmodule

// File: rtl/mxfer_seq_chk.sv
module mxfer_seq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        ctrl_we_i,
  input logic [15:0] ctrl_wdata_i,
  input logic [15:0] ctrl_o,
  input logic [15:0] cnt_o,
  input logic [1:0]  stat_clr_i,
  input logic        nack_o,
  input logic        ardy_o,
  input logic        busy_o,
  input logic        eng_req_o,
  input logic [1:0]  eng_op_o,
  input logic [7:0]  eng_data_o,
  input logic        eng_done_i,
  input logic        eng_ack_i
);
  logic fin;
  assign fin = eng_req_o && eng_done_i;

  // R2
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_req_o && !eng_done_i |=> eng_req_o && $stable(eng_op_o) && $stable(eng_data_o));
  // R2
  stt_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin && eng_op_o == 2'd0 |=> !ctrl_o[0]);
  // R3
  start_nack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin && eng_op_o == 2'd0 && !eng_ack_i && !stat_clr_i[0] |=> nack_o && !busy_o);
  // R6
  ardy_mst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ardy_o) |-> !ctrl_o[10]);
  // R7
  stop_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin && eng_op_o == 2'd3 |=> !ctrl_o[1] && !busy_o);
  // R9
  rpt_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && ctrl_o[2] && !ctrl_we_i && !(fin && eng_op_o == 2'd3) |=> $stable(cnt_o));
  // R11
  send_nack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin && eng_op_o == 2'd1 && !eng_ack_i && !stat_clr_i[0] |=> nack_o && !ctrl_o[1] && !busy_o);
  // R12
  no_master_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && ctrl_we_i && (!ctrl_wdata_i[10] || ctrl_wdata_i[8]) |=> !eng_req_o);
endmodule

bind mxfer_seq mxfer_seq_chk u_chk (
  .clk_i, .rst_ni, .ctrl_we_i, .ctrl_wdata_i, .ctrl_o, .cnt_o, .stat_clr_i,
  .nack_o, .ardy_o, .busy_o, .eng_req_o, .eng_op_o, .eng_data_o, .eng_done_i, .eng_ack_i
);

// File: tb/mxfer_seq_bench.sv
`timescale 1ns/1ps
module mxfer_seq_bench;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        ctrl_we_i = 1'b0;
  logic [15:0] ctrl_wdata_i = '0, ctrl_o;
  logic [9:0]  sa_i = 10'h055;
  logic        cnt_we_i = 1'b0;
  logic [15:0] cnt_wdata_i = '0, cnt_o;
  logic        wr_push_i = 1'b0, rd_pop_i = 1'b0;
  logic [7:0]  wr_byte_i = '0, rd_byte_o;
  logic [1:0]  stat_clr_i = '0;
  logic        nack_o, ardy_o, rrdy_o, xrdy_o, busy_o, eng_req_o;
  logic [1:0]  eng_op_o;
  logic [7:0]  eng_data_o;
  logic        eng_done_i = 1'b0, eng_ack_i = 1'b0;
  logic [7:0]  eng_rdata_i = '0;

  mxfer_seq u_mxfer_seq (.*);

  always #2.5 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0;
  bit done_flag = 0;
  logic [1:0] op_log [64];
  logic [7:0] dat_log [64];
  int n_log = 0, send_cnt = 0, recv_cnt = 0, nack_idx = -1;
  bit start_ack = 1;

  // engine model: answers each request two cycles after it shows up
  always begin
    @(negedge clk_i);
    if (eng_req_o) begin
      if (n_log < 64) begin
        op_log[n_log]  = eng_op_o;
        dat_log[n_log] = eng_data_o;
      end
      n_log++;
      repeat (2) @(negedge clk_i);
      eng_ack_i   = 1'b1;
      eng_rdata_i = 8'hA0 + 8'(recv_cnt);
      if (eng_op_o == 2'd0) eng_ack_i = start_ack;
      if (eng_op_o == 2'd1) begin
        eng_ack_i = (send_cnt != nack_idx);
        send_cnt++;
      end
      if (eng_op_o == 2'd2) recv_cnt++;
      eng_done_i = 1'b1;
      @(negedge clk_i);
      eng_done_i = 1'b0;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic ctrl_wr(logic [15:0] v);
    @(negedge clk_i); ctrl_we_i = 1'b1; ctrl_wdata_i = v;
    @(negedge clk_i); ctrl_we_i = 1'b0;
  endtask

  task automatic cnt_wr(logic [15:0] v);
    @(negedge clk_i); cnt_we_i = 1'b1; cnt_wdata_i = v;
    @(negedge clk_i); cnt_we_i = 1'b0;
  endtask

  task automatic push(logic [7:0] b);
    @(negedge clk_i); wr_push_i = 1'b1; wr_byte_i = b;
    @(negedge clk_i); wr_push_i = 1'b0;
  endtask

  task automatic pop(string req, logic [7:0] exp);
    @(negedge clk_i);
    chk(req, "popped byte", int'(rd_byte_o), int'(exp));
    rd_pop_i = 1'b1;
    @(negedge clk_i); rd_pop_i = 1'b0;
  endtask

  task automatic sclr(logic [1:0] m);
    @(negedge clk_i); stat_clr_i = m;
    @(negedge clk_i); stat_clr_i = '0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk_i);
      if (!busy_o && !eng_req_o) break;
    end
    @(negedge clk_i);
  endtask

  task automatic wait_x();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk_i);
      if (xrdy_o) break;
    end
  endtask

  task automatic wait_r();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk_i);
      if (rrdy_o) break;
    end
  endtask

  task automatic fresh();
    n_log = 0; send_cnt = 0; recv_cnt = 0;
  endtask

  task automatic t_reset();
    chk("R1", "ctrl after reset", int'(ctrl_o), 0);
    chk("R4", "cnt after reset", int'(cnt_o), 0);
    chk("R13", "flags after reset", int'({nack_o, ardy_o, rrdy_o, xrdy_o, busy_o, eng_req_o}), 0);
  endtask

  task automatic t_mask();
    fresh();
    ctrl_wr(16'h7fff);
    chk("R1", "masked ctrl", int'(ctrl_o), 16'h4f87);
    repeat (10) @(negedge clk_i);
    chk("R1", "no command when disabled", n_log, 0);
    ctrl_wr(16'h0000);
  endtask

  task automatic t_no_master();
    fresh();
    ctrl_wr(16'h8001);
    repeat (20) @(negedge clk_i);
    chk("R12", "no command without master", n_log, 0);
    chk("R12", "idle without master", int'(busy_o), 0);
    ctrl_wr(16'h8501);
    repeat (20) @(negedge clk_i);
    chk("R12", "no command with wide address", n_log, 0);
    ctrl_wr(16'h0000);
  endtask

  task automatic t_tx_count();
    fresh();
    sa_i = 10'h055;
    cnt_wr(16'd3);
    push(8'h11); push(8'h22);
    ctrl_wr(16'h8603);
    wait_x();
    chk("R5", "xrdy with count left", int'(xrdy_o), 1);
    chk("R4", "count after two sends", int'(cnt_o), 1);
    chk("R2", "start bit self cleared", int'(ctrl_o[0]), 0);
    chk("R2", "start op", int'(op_log[0]), 0);
    chk("R2", "start address byte", int'(dat_log[0]), 8'hAA);
    chk("R5", "first send", int'({op_log[1], dat_log[1]}), {2'd1, 8'h11});
    chk("R5", "second send", int'({op_log[2], dat_log[2]}), {2'd1, 8'h22});
    push(8'h33);
    chk("R5", "xrdy cleared by push", int'(xrdy_o), 0);
    wait_idle();
    chk("R5", "third send", int'({op_log[3], dat_log[3]}), {2'd1, 8'h33});
    chk("R7", "stop issued", int'(op_log[4]), 3);
    chk("R7", "command count", n_log, 5);
    chk("R6", "ardy set", int'(ardy_o), 1);
    chk("R6", "master released", int'(ctrl_o[10]), 0);
    chk("R6", "xrdy low at end", int'(xrdy_o), 0);
    chk("R7", "stop bit cleared", int'(ctrl_o[1]), 0);
    chk("R7", "count reloaded", int'(cnt_o), 3);
    sclr(2'b10);
    chk("R13", "ardy cleared", int'(ardy_o), 0);
    ctrl_wr(16'h0000);
  endtask

  task automatic t_rx_count();
    fresh();
    sa_i = 10'h02A;
    cnt_wr(16'd6);
    ctrl_wr(16'h8403);
    wait_r();
    repeat (20) @(negedge clk_i);
    chk("R8", "rrdy when full", int'(rrdy_o), 1);
    chk("R8", "stalled at four bytes", n_log, 5);
    chk("R2", "read address byte", int'(dat_log[0]), 8'h55);
    chk("R4", "count after four", int'(cnt_o), 2);
    for (int i = 0; i < 4; i++) pop("R8", 8'hA0 + 8'(i));
    wait_idle();
    chk("R8", "all receives and stop", n_log, 8);
    chk("R7", "stop last", int'(op_log[7]), 3);
    chk("R8", "rrdy at count end", int'(rrdy_o), 1);
    chk("R6", "ardy after receive", int'(ardy_o), 1);
    pop("R8", 8'hA4);
    pop("R8", 8'hA5);
    chk("R8", "rrdy cleared when empty", int'(rrdy_o), 0);
    sclr(2'b10);
    ctrl_wr(16'h0000);
  endtask

  task automatic t_rpt_tx();
    fresh();
    sa_i = 10'h011;
    cnt_wr(16'd5);
    push(8'h5A); push(8'h5B); push(8'h5C);
    ctrl_wr(16'h8605);
    wait_x();
    repeat (20) @(negedge clk_i);
    chk("R9", "drained, no stop", n_log, 4);
    chk("R9", "last send", int'({op_log[3], dat_log[3]}), {2'd1, 8'h5C});
    chk("R9", "still busy", int'(busy_o), 1);
    chk("R9", "count untouched", int'(cnt_o), 5);
    chk("R9", "no ardy", int'(ardy_o), 0);
    ctrl_wr(16'h8606);
    wait_idle();
    chk("R9", "stop on request", int'({n_log[7:0], 6'd0, op_log[4]}), {8'd5, 6'd0, 2'd3});
    chk("R9", "master kept", int'(ctrl_o[10]), 1);
    chk("R7", "stop cleared", int'(ctrl_o[1]), 0);
    ctrl_wr(16'h0000);
  endtask

  task automatic t_rpt_rx();
    fresh();
    ctrl_wr(16'h8405);
    wait_r();
    repeat (20) @(negedge clk_i);
    chk("R10", "one byte per step", n_log, 2);
    chk("R10", "receive op", int'(op_log[1]), 2);
    pop("R10", 8'hA0);
    wait_r();
    repeat (10) @(negedge clk_i);
    chk("R10", "second step", n_log, 3);
    ctrl_wr(16'h8406);
    wait_idle();
    chk("R10", "stop after request", int'({n_log[7:0], 6'd0, op_log[3]}), {8'd4, 6'd0, 2'd3});
    pop("R10", 8'hA1);
    chk("R10", "rrdy cleared", int'(rrdy_o), 0);
    ctrl_wr(16'h0000);
  endtask

  task automatic t_start_nack();
    fresh();
    start_ack = 0;
    ctrl_wr(16'h8603);
    wait_idle();
    chk("R3", "only start issued", n_log, 1);
    chk("R3", "nack set", int'(nack_o), 1);
    chk("R3", "start bit cleared", int'(ctrl_o[0]), 0);
    start_ack = 1;
    sclr(2'b01);
    chk("R13", "nack cleared", int'(nack_o), 0);
    ctrl_wr(16'h0000);
  endtask

  task automatic t_data_nack();
    fresh();
    nack_idx = 0;
    cnt_wr(16'd2);
    push(8'h71); push(8'h72);
    ctrl_wr(16'h8603);
    wait_idle();
    chk("R11", "no stop after nack", n_log, 2);
    chk("R11", "nack set", int'(nack_o), 1);
    chk("R11", "stop bit cleared", int'(ctrl_o[1]), 0);
    pop("R11", 8'h72);
    nack_idx = -1;
    sclr(2'b01);
    ctrl_wr(16'h0000);
  endtask

  initial begin
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_mask();
    t_no_master();
    t_tx_count();
    t_rx_count();
    t_rpt_tx();
    t_rpt_rx();
    t_start_nack();
    t_data_nack();
    if (!done_flag) begin
      done_flag = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!done_flag) begin
      done_flag = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule